// File: doc/BRIEF.md
# Trimmable Hardware Time Counter

This block keeps a 64-bit count of time in units of 8 ns. On every clock cycle it adds a 32-bit rate word to a fractional accumulator. The whole ticks that come out of that sum advance the counter, and the remainder stays in the accumulator for later cycles. Software can therefore trim the counter's speed around nominal without losing any fraction of a tick. The intended trim range is about ±3.2% (0.968x to 1.032x).

Four 32-bit word registers are reached over a plain register bus:

- **Command word.** Holds a sticky mode bit (load or add) and a self-clearing request that zeroes the time.
- **Rate word.**
- **Value low half.**
- **Value high half.** Writing this half commits the staged 64-bit value, which either replaces the counter or is added to it as a signed tick offset, depending on the mode.

The full count is also exported on a dedicated port for timestamping logic.

Top module: `phc_core`

## Requirements
- R1: After reset the count is 0, the rate word reads 0x8000_0000, and the command readback is 0, which means load mode with no pending clear.
- R2: With the rate word at 0x8000_0000, the count advances by exactly one per clock cycle.
- R3: The per-cycle advance is computed as follows. Each cycle, the sum of the carried fraction and the rate word, read as a value with 31 fractional bits, is taken. The advance is the integer part of that sum, and the fraction is carried into the next cycle. For example, 0xC000_0000 gives 12 ticks in 8 cycles.
- R4: A write to command word 0 takes effect only if bit 31 of the write data is 1. Otherwise the write changes nothing.
- R5: Command bit 0 selects the mode: 1 means add and 0 means load. The mode keeps its value across any number of value writes until a valid command changes it.
- R6: Writing word 2 stages the low half of the value. Writing word 3 supplies the high half and commits. In load mode, the count after the commit edge equals the 64-bit value exactly, with no advance added in that cycle.
- R7: In add mode, the committed value is a two's-complement tick offset. It is added together with that cycle's normal advance, so no tick is lost.
- R8: A valid command with bit 2 set clears the count and the fraction on the following edge. Command readback bit 2 reads 1 for exactly the one cycle between these two edges. A word-3 commit that lands on that cycle is discarded.
- R9: Reads are decoded as follows:
  - Word 0 returns the mode in bit 0 and the pending clear in bit 2, with all other bits 0.
  - Word 1 returns the rate word.
  - Words 2 and 3 return the low and high halves of the count.
  - The counter carries from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register word select |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 32 | Combinational read data for addr_i |
| count_o | output | 64 | Current time count |

## Verification
A wrong fractional accumulator does not show up as a single bad value. It shows up as drift: after a run of cycles at a trimmed rate, the count is off by a tick or more. The bench therefore compares count differences over windows of 8 and 256 cycles against exact rational sums. A wrong mode bit or commit path shows up at count_o on the edge right after the high-half write. A lost clear shows up one edge after the command. The bench samples at exactly those edges.

// File: rtl/phc_pkg.sv
`timescale 1ns/1ps
package phc_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    REG_CMD    = 2'd0,
    REG_RATE   = 2'd1,
    REG_VAL_LO = 2'd2,
    REG_VAL_HI = 2'd3
  } reg_sel_e;

  localparam int CMD_VALID_BIT = 31;
  localparam int CMD_CLR_BIT   = 2;
  localparam int CMD_ADD_BIT   = 0;
endpackage

// File: rtl/phc_rate_accum.sv
`timescale 1ns/1ps
module phc_rate_accum #(
  parameter int RATE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [1:0]        ticks_o
);
  localparam int FRAC_W = RATE_W - 1;
  localparam logic [RATE_W-1:0] RATE_NOM = RATE_W'(1) << FRAC_W;

  logic [FRAC_W-1:0] frac_q;
  logic [RATE_W:0]   sum;

  // rate is Q1.FRAC_W; integer part of (frac + rate) is the advance
  assign sum     = {2'b00, frac_q} + {1'b0, rate_i};
  assign ticks_o = sum[RATE_W:FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frac_q <= '0;
    else if (clear_i) frac_q <= '0;
    else              frac_q <= sum[FRAC_W-1:0];
  end

  p_nominal_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == RATE_NOM) |-> (ticks_o == 2'd1));
  p_step_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ticks_o <= 2'd2);
  p_frac_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && (rate_i == RATE_NOM) |=> (ticks_o == 2'd1));
endmodule

// File: rtl/phc_regs.sv
`timescale 1ns/1ps
module phc_regs
  import phc_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     addr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           we_i,
  input  logic [2*W-1:0] count_i,
  output logic [W-1:0]   rate_o,
  output logic           add_mode_o,
  output logic           clear_o,
  output logic           commit_o,
  output logic [2*W-1:0] value_o,
  output logic [W-1:0]   rdata_o
);
  localparam logic [W-1:0] RATE_NOM = W'(1) << (W - 1);

  logic         cmd_wr;
  logic         clr_pend_q;
  logic         mode_q;
  logic [W-1:0] rate_q;
  logic [W-1:0] lo_q;

  assign cmd_wr = we_i && (addr_i == REG_CMD) && wdata_i[CMD_VALID_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_pend_q <= 1'b0;
      mode_q     <= 1'b0;
      rate_q     <= RATE_NOM;
      lo_q       <= '0;
    end else begin
      clr_pend_q <= cmd_wr && wdata_i[CMD_CLR_BIT];
      if (cmd_wr)                           mode_q <= wdata_i[CMD_ADD_BIT];
      if (we_i && addr_i == REG_RATE)       rate_q <= wdata_i;
      if (we_i && addr_i == REG_VAL_LO)     lo_q   <= wdata_i;
    end
  end

  assign rate_o     = rate_q;
  assign add_mode_o = mode_q;
  assign clear_o    = clr_pend_q;
  // clear takes priority over a commit in the same cycle
  assign commit_o   = we_i && (addr_i == REG_VAL_HI) && !clr_pend_q;
  assign value_o    = {wdata_i, lo_q};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CMD: begin
        rdata_o[CMD_ADD_BIT] = mode_q;
        rdata_o[CMD_CLR_BIT] = clr_pend_q;
      end
      REG_RATE:   rdata_o = rate_q;
      REG_VAL_LO: rdata_o = count_i[W-1:0];
      default:    rdata_o = count_i[2*W-1:W];
    endcase
  end

  p_mode_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_CMD && wdata_i[CMD_VALID_BIT]) |=> $stable(add_mode_o));
  p_clear_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o && !(we_i && addr_i == REG_CMD) |=> !clear_o);
  p_invalid_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == REG_CMD && !wdata_i[CMD_VALID_BIT] |=> !clear_o);
endmodule

// File: rtl/phc_time_cnt.sv
`timescale 1ns/1ps
module phc_time_cnt #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             add_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic [1:0]       ticks_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step;

  assign step = CNT_W'(ticks_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (load_i && !add_i) cnt_q <= value_i;
    else if (load_i)          cnt_q <= cnt_q + step + value_i;
    else                      cnt_q <= cnt_q + step;
  end

  assign count_o = cnt_q;

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));
  p_load_exact_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !add_i && !clear_i |=> (count_o == $past(value_i)));
  p_free_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !clear_i |=> (count_o - $past(count_o) == CNT_W'($past(ticks_i))));
endmodule

// File: rtl/phc_core.sv
`timescale 1ns/1ps
module phc_core
  import phc_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     addr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           we_i,
  output logic [W-1:0]   rdata_o,
  output logic [2*W-1:0] count_o
);
  localparam int CNT_W = 2 * W;

  logic [W-1:0]     rate;
  logic             add_mode;
  logic             clear;
  logic             commit;
  logic [CNT_W-1:0] value;
  logic [1:0]       ticks;
  logic [CNT_W-1:0] count;

  phc_regs #(.W(W)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .count_i(count), .rate_o(rate), .add_mode_o(add_mode),
    .clear_o(clear), .commit_o(commit), .value_o(value), .rdata_o(rdata_o)
  );

  phc_rate_accum #(.RATE_W(W)) accum_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .rate_i(rate),
    .ticks_o(ticks)
  );

  phc_time_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .load_i(commit),
    .add_i(add_mode), .value_i(value), .ticks_i(ticks), .count_o(count)
  );

  assign count_o = count;

  p_export_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_VAL_HI) |-> (rdata_o == count_o[CNT_W-1:W]));
endmodule

// File: tb/phc_core_tb.sv
`timescale 1ns/1ps
module phc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [63:0] count;
  int n_checks = 0;
  int n_errors = 0;
  logic [63:0] c0;

  always #2 clk = ~clk;

  phc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .count_o(count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk("R1 count", count, 64'd0);
    rd(2'd1, d); chk("R1 rate", {32'd0, d}, 64'h8000_0000);
    rd(2'd0, d); chk("R1 cmd", {32'd0, d}, 64'd0);
  endtask

  task automatic t_nominal();
    c0 = count; wait_n(10);
    chk("R2 nominal advance", count, c0 + 64'd10);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'h0000_0005);
    chk("R6 load exact", count, 64'h5_FFFF_FFFE);
    wait_n(3);
    chk("R9 carry", count, 64'h6_0000_0001);
    rd(2'd3, d); chk("R9 read high", {32'd0, d}, 64'h6);
    rd(2'd2, d); chk("R9 read low", {32'd0, d}, 64'h1);
  endtask

  task automatic t_add();
    logic [31:0] d;
    wr(2'd0, 32'h8000_0001);
    rd(2'd0, d); chk("R5 mode readback", {32'd0, d}, 64'h1);
    c0 = count;
    wr(2'd2, 32'hFFFF_FF9C); wr(2'd3, 32'hFFFF_FFFF);
    chk("R7 negative offset", count, c0 + 64'd2 - 64'd100);
    c0 = count;
    wr(2'd2, 32'd1000); wr(2'd3, 32'd0);
    chk("R5 sticky add", count, c0 + 64'd1002);
  endtask

  task automatic t_invalid_cmd();
    logic [31:0] d;
    wr(2'd0, 32'h0000_0004);
    rd(2'd0, d); chk("R4 ignored cmd", {32'd0, d}, 64'h1);
    c0 = count;
    wr(2'd2, 32'd5); wr(2'd3, 32'd0);
    chk("R4 still add mode", count, c0 + 64'd7);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(2'd0, 32'h8000_0004);
    rd(2'd0, d); chk("R8 pending visible", {32'd0, d}, 64'h4);
    wr(2'd3, 32'h0000_0077);
    chk("R8 cleared, commit dropped", count, 64'd0);
    rd(2'd0, d); chk("R8 self-clear", {32'd0, d}, 64'h0);
    @(negedge clk);
    chk("R8 restart", count, 64'd1);
  endtask

  task automatic t_rate();
    logic [31:0] d;
    wr(2'd1, 32'hC000_0000);
    rd(2'd1, d); chk("R9 rate readback", {32'd0, d}, 64'hC000_0000);
    c0 = count; wait_n(8);
    chk("R3 fast 1.5x", count, c0 + 64'd12);
    wr(2'd1, 32'h4000_0000);
    c0 = count; wait_n(8);
    chk("R3 slow 0.5x", count, c0 + 64'd4);
    wr(2'd1, 32'h8100_0000);
    c0 = count; wait_n(256);
    chk("R3 fine trim", count, c0 + 64'd258);
  endtask

  initial begin
    wait_n(3);
    t_reset_state();
    rst_n = 1'b1;
    t_nominal();
    t_load();
    t_add();
    t_invalid_cmd();
    t_clear();
    t_rate();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule